// File: doc/BRIEF.md
# Bit-Field Word Extract/Insert Unit

This block holds a single 36-bit word and serves commands that read or replace an arbitrary bit field inside it. A field is named by a descriptor made of two numbers: an offset, which is the count of word bits lying below the field, and a length from 0 to 36. A read command returns the field shifted down to bit 0 and zero-filled above. A write command replaces the field with the low bits of the supplied data and leaves every other bit of the word as it was.

A field has to fit inside the word. Any descriptor whose offset plus length exceeds the word width is refused: the response is flagged as an error and the word is not changed. Commands arrive on a valid/ready channel and each produces exactly one response on a second valid/ready channel, one cycle after it is accepted. The block accepts a new command only when its response register is empty or is being drained in the same cycle. As a result, a stalled consumer holds back the command side without any loss of data.

Top module: `bfu_word_top`

## Requirements
- R1: After synchronous active-low reset, the stored word is all zeros and `rsp_valid` is 0.
- R2: `cmd_ready` is high exactly when `rsp_valid` is 0 or `rsp_ready` is 1. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high, and its response appears with `rsp_valid` = 1 after that same edge.
- R3: While `rsp_valid` = 1 and `rsp_ready` = 0, `rsp_valid`, `rsp_data` and `rsp_err` hold their values.
- R4: A read (`cmd_op` = 0) with a legal descriptor returns word bits `offset` to `offset+len-1` in `rsp_data` bits 0 to `len-1`, with all higher bits 0. It leaves the word unchanged.
- R5: A write (`cmd_op` = 1) with a legal descriptor sets word bits `offset` to `offset+len-1` to `cmd_data` bits 0 to `len-1` and keeps all other word bits. The updated word is returned in `rsp_data` and is the word seen by the next command.
- R6: With length 0, a read returns 0 and a write leaves the word unchanged.
- R7: When offset + length > 36, the response has `rsp_err` = 1 and `rsp_data` = 0, and the word is unchanged. Offset + length = 36 is legal and gives `rsp_err` = 0.
- R8: Length 36 at offset 0 addresses the whole word. A read returns the whole word, and a write replaces it with `cmd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 1 | 0 = read field, 1 = write field |
| cmd_off | input | 6 | Field offset (bits below the field) |
| cmd_len | input | 6 | Field length, 0 to 36 legal |
| cmd_data | input | 36 | Write data; the low `len` bits are used |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 36 | Extracted field or updated word |
| rsp_err | output | 1 | Descriptor exceeded the word |

## Verification
The bench builds the block with its default 36-bit word and 6-bit offset and length fields. With these widths, offsets and lengths up to 63 can be driven, so both descriptors just past the word edge and descriptors far beyond it reach the error path. The bench also covers the exact-fit case where offset plus length equals 36, along with zero-length and full-word fields. A stretch with `rsp_ready` held low exercises the hold and back-pressure rules.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic {
    BFU_READ  = 1'b0,
    BFU_WRITE = 1'b1
  } bfu_op_e;
endpackage

// File: rtl/bfu_desc_check.sv
module bfu_desc_check #(
  parameter int WORD_W = 36,
  parameter int POS_W  = 6
) (
  input  logic [POS_W-1:0]  off,
  input  logic [POS_W-1:0]  len,
  output logic              err,
  output logic [WORD_W-1:0] low_mask,
  output logic [WORD_W-1:0] fld_mask
);
  localparam logic [POS_W:0] LIMIT = (POS_W+1)'(WORD_W);

  logic [POS_W:0] end_pos;
  assign end_pos = {1'b0, off} + {1'b0, len};
  assign err     = end_pos > LIMIT;

  for (genvar i = 0; i < WORD_W; i++) begin : g_mask
    localparam logic [POS_W:0] IDX = (POS_W+1)'(i);
    assign low_mask[i] = IDX < {1'b0, len};
    assign fld_mask[i] = (IDX >= {1'b0, off}) && (IDX < end_pos);
  end
endmodule

// File: rtl/bfu_extract.sv
module bfu_extract #(
  parameter int WORD_W = 36,
  parameter int POS_W  = 6
) (
  input  logic [WORD_W-1:0] word,
  input  logic [POS_W-1:0]  off,
  input  logic [WORD_W-1:0] low_mask,
  output logic [WORD_W-1:0] field
);
  logic [WORD_W-1:0] shifted;
  assign shifted = word >> off;
  assign field   = shifted & low_mask;
endmodule

// File: rtl/bfu_insert.sv
module bfu_insert #(
  parameter int WORD_W = 36,
  parameter int POS_W  = 6
) (
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] data,
  input  logic [POS_W-1:0]  off,
  input  logic [WORD_W-1:0] fld_mask,
  output logic [WORD_W-1:0] merged
);
  logic [WORD_W-1:0] placed;
  assign placed = data << off;
  assign merged = (word & ~fld_mask) | (placed & fld_mask);
endmodule

// File: rtl/bfu_word_top.sv
module bfu_word_top #(
  parameter int WORD_W = 36,
  parameter int POS_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_op,
  input  logic [POS_W-1:0]  cmd_off,
  input  logic [POS_W-1:0]  cmd_len,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_err
);
  import bfu_pkg::*;

  logic [WORD_W-1:0] word_q;
  logic              desc_err;
  logic [WORD_W-1:0] low_mask, fld_mask, field, merged;
  logic              accept;
  bfu_op_e           op;

  assign op        = bfu_op_e'(cmd_op);
  assign cmd_ready = !rsp_valid || rsp_ready;
  assign accept    = cmd_valid && cmd_ready;

  bfu_desc_check #(.WORD_W(WORD_W), .POS_W(POS_W)) u_check (
    .off(cmd_off), .len(cmd_len), .err(desc_err),
    .low_mask(low_mask), .fld_mask(fld_mask)
  );

  bfu_extract #(.WORD_W(WORD_W), .POS_W(POS_W)) u_extract (
    .word(word_q), .off(cmd_off), .low_mask(low_mask), .field(field)
  );

  bfu_insert #(.WORD_W(WORD_W), .POS_W(POS_W)) u_insert (
    .word(word_q), .data(cmd_data), .off(cmd_off),
    .fld_mask(fld_mask), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= desc_err;
      if (desc_err) begin
        rsp_data <= '0;
      end else if (op == BFU_READ) begin
        rsp_data <= field;
      end else begin
        rsp_data <= merged;
        word_q   <= merged;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // Checks placed beside the response and word registers
  assert_accept_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  assert_rsp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));

  assert_read_keeps_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == BFU_READ |=> $stable(word_q));

  assert_read_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == BFU_READ && !desc_err && cmd_len < POS_W'(WORD_W)
    |=> (rsp_data >> $past(cmd_len)) == '0);

  assert_mask_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !desc_err |-> $countones(fld_mask) == int'(cmd_len));

  assert_zero_len_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_len == '0 && op == BFU_WRITE |=> $stable(word_q));

  assert_bad_desc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && desc_err |=> $stable(word_q) && rsp_err && rsp_data == '0);
endmodule

// File: tb/bfu_word_top_tb_top.sv
module bfu_word_top_tb_top;
  localparam int W = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_op = 1'b0;
  logic [5:0]    cmd_off = '0;
  logic [5:0]    cmd_len = '0;
  logic [W-1:0]  cmd_data = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [W-1:0]  rsp_data;
  logic          rsp_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] model_word = '0;

  always #2 clk = ~clk;

  bfu_word_top dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_off(cmd_off), .cmd_len(cmd_len), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_err(rsp_err)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_read(input logic [W-1:0] w, input int off, input int len);
    logic [W-1:0] r = '0;
    for (int i = 0; i < len; i++) r[i] = w[off+i];
    return r;
  endfunction

  function automatic logic [W-1:0] ref_write(input logic [W-1:0] w, input logic [W-1:0] d,
                                             input int off, input int len);
    logic [W-1:0] r = w;
    for (int i = 0; i < len; i++) r[off+i] = d[i];
    return r;
  endfunction

  // Issue one command with rsp_ready high and compare against the model
  task automatic run_cmd(input string req, input logic op, input int off, input int len,
                         input logic [W-1:0] data);
    logic bad;
    logic [W-1:0] exp;
    bad = (off + len) > W;
    @(negedge clk);
    check({req, " ready"}, {35'd0, cmd_ready}, 36'd1);
    cmd_valid = 1'b1; cmd_op = op; cmd_off = 6'(off); cmd_len = 6'(len); cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (bad) exp = '0;
    else if (op == 1'b0) exp = ref_read(model_word, off, len);
    else begin
      model_word = ref_write(model_word, data, off, len);
      exp = model_word;
    end
    check({req, " valid"}, {35'd0, rsp_valid}, 36'd1);
    check({req, " err"}, {35'd0, rsp_err}, {35'd0, bad});
    check({req, " data"}, rsp_data, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 rsp_valid", {35'd0, rsp_valid}, 36'd0);
    check("R1 ready", {35'd0, cmd_ready}, 36'd1);
    run_cmd("R1 word", 1'b0, 0, 36, '0);
  endtask

  task automatic t_write_read;
    run_cmd("R8 full write", 1'b1, 0, 36, 36'h9_ABCD_1234);
    run_cmd("R8 full read", 1'b0, 0, 36, '0);
    run_cmd("R5 mid write", 1'b1, 7, 9, 36'hF_FFFF_F155);
    run_cmd("R4 mid read", 1'b0, 7, 9, '0);
    run_cmd("R4 low read", 1'b0, 0, 5, '0);
    run_cmd("R5 top write", 1'b1, 30, 6, 36'h0_0000_002A);
    run_cmd("R4 top read", 1'b0, 28, 8, '0);
    run_cmd("R5 one bit", 1'b1, 35, 1, 36'h0_0000_0000);
    run_cmd("R4 one bit", 1'b0, 35, 1, '0);
    run_cmd("R4 wide read", 1'b0, 3, 30, '0);
  endtask

  task automatic t_zero_len;
    run_cmd("R6 zero read", 1'b0, 12, 0, '0);
    run_cmd("R6 zero write", 1'b1, 12, 0, 36'hF_FFFF_FFFF);
    run_cmd("R6 zero write at edge", 1'b1, 36, 0, 36'hF_FFFF_FFFF);
    run_cmd("R6 word after", 1'b0, 0, 36, '0);
  endtask

  task automatic t_bounds;
    run_cmd("R7 exact fit write", 1'b1, 20, 16, 36'h0_0000_BEEF);
    run_cmd("R7 over by one write", 1'b1, 21, 16, 36'h0_0000_0000);
    run_cmd("R7 over by one read", 1'b0, 1, 36, '0);
    run_cmd("R7 far offset write", 1'b1, 63, 1, 36'hF_FFFF_FFFF);
    run_cmd("R7 huge len", 1'b1, 0, 63, 36'h0);
    run_cmd("R7 word kept", 1'b0, 0, 36, '0);
  endtask

  task automatic t_backpressure;
    logic [W-1:0] held;
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_valid = 1'b1; cmd_op = 1'b0; cmd_off = 6'd4; cmd_len = 6'd12; cmd_data = '0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 1'b1; cmd_off = 6'd0; cmd_len = 6'd36; cmd_data = '0;
    held = rsp_data;
    check("R2 valid after accept", {35'd0, rsp_valid}, 36'd1);
    check("R4 stalled data", held, ref_read(model_word, 4, 12));
    for (int k = 0; k < 3; k++) begin
      check("R2 ready low", {35'd0, cmd_ready}, 36'd0);
      @(negedge clk);
      check("R3 valid held", {35'd0, rsp_valid}, 36'd1);
      check("R3 data held", rsp_data, held);
    end
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R2 drained", {35'd0, rsp_valid}, 36'd0);
    run_cmd("R3 write not taken while stalled", 1'b0, 0, 36, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_zero_len();
    t_bounds();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule